// File: doc/BRIEF.md
# Serial Flash Write-Permission Sequencer

This block sits behind the byte deserializer of a serial NOR flash front end. The deserializer reports the first byte of each frame as an opcode, reports every later byte separately, and signals when chip enable rises. It also says whether chip enable rose on a byte boundary. The sequencer gathers address and payload bytes for the current frame. It decides at the end of the frame whether the instruction may reach the program/erase engine. When it may, the sequencer issues a single-cycle request that carries a kind code, a target address and a payload.

The sequencer holds four pieces of state: the write-permit latch, a one-shot status-write permit, the auto-increment programming context and the busy-on-output mode. Together these enforce the ordering rules. Erasing or programming needs a prior permit. A status write must come directly after its arming instruction. An auto-increment program run carries its own address forward, so that each continuation frame supplies only two payload bytes.

Top module: `flash_wguard`

## Requirements
- R1: Reset clears the write-permit latch, the status-write permit, the auto-increment context and the busy-output mode, and holds `req_valid` low.
- R2: A complete frame with opcode 06h and no further bytes sets the write-permit latch. Opcode 04h clears it. The latch is visible as `status` bit 1 from the cycle after chip enable rises.
- R3: Byte program (02h), 4 KB erase (20h), 64 KB erase (D8h) and whole-array erase (60h or C7h) produce a request only while the write-permit latch is set. Otherwise no request appears and the latch keeps its value.
- R4: Request kinds on `req_kind` are 1 byte program, 2 sector erase, 3 block erase, 4 array erase, 5 auto-increment word, 6 status write. A sector erase address has bits 11:0 forced to zero. A block erase address has bits 15:0 forced to zero. An array erase and a status write carry address zero.
- R5: A frame produces no request and no state change unless chip enable rises on a byte boundary after exactly the byte count its opcode needs: 4 for 02h, 3 for an erase with address, 1 for 01h, 5 for the first ADh, 2 for a continuing ADh, and 0 otherwise.
- R6: A status write (01h plus one data byte, payload in `req_data[7:0]`) is issued only when the frame directly before it was a complete 50h frame. Any other frame in between withdraws the permit.
- R7: The first ADh frame takes a 3-byte address and two data bytes (first byte in `req_data[15:8]`). Each later ADh frame takes two data bytes and targets the previous address plus 2. While this context is open, all other program and erase opcodes are refused.
- R8: The write-permit latch clears when a byte program, erase or status write is accepted. It stays set through an auto-increment run. A 04h frame ends the run and clears the latch.
- R9: Opcode 70h turns on busy-output mode and 80h turns it off. `so_busy_sel` is high exactly while that mode is on and an auto-increment run is open.
- R10: `status` bit 0 follows `busy_in`. While `busy_in` is high no new request is accepted, except an auto-increment continuation.
- R11: `req_valid` is high for exactly one cycle per accepted instruction, in the cycle after chip enable rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Pulse: opcode byte of a new frame is on `op_code` |
| op_code | input | 8 | Opcode byte |
| byte_valid | input | 1 | Pulse: a following byte is on `byte_data` |
| byte_data | input | 8 | Address or payload byte, most significant first |
| cs_end | input | 1 | Pulse: chip enable rose, frame over |
| cs_aligned | input | 1 | With `cs_end`: the rise came on a byte boundary |
| busy_in | input | 1 | Program/erase engine busy |
| req_valid | output | 1 | One-cycle request to the engine |
| req_kind | output | 3 | Request kind code |
| req_addr | output | ADDR_W | Target address |
| req_data | output | 16 | Payload |
| status | output | 8 | Bit 0 busy, bit 1 write-permit latch, rest zero |
| aai_active | output | 1 | Auto-increment run open |
| so_busy_sel | output | 1 | Serial output should carry busy |

## Verification
The hardest case to reach is an auto-increment continuation accepted while the engine is busy. The same busy state must still block every other request, and the permit latch must survive the whole run. The stimulus reaches it in order: 70h, a permit, a first ADh, then a continuation with `busy_in` high and an erase attempted mid-run. A closing 04h and a second run without the output mode complete the case. The one-shot status permit is reached by putting an unrelated frame between 50h and 01h.

// File: rtl/flash_wguard_pkg.sv
package flash_wguard_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SECT  = 8'h20;
  localparam logic [7:0] OP_BLOCK = 8'hD8;
  localparam logic [7:0] OP_CHIPA = 8'h60;
  localparam logic [7:0] OP_CHIPB = 8'hC7;
  localparam logic [7:0] OP_EWSR  = 8'h50;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_AAI   = 8'hAD;
  localparam logic [7:0] OP_BOON  = 8'h70;
  localparam logic [7:0] OP_BOOFF = 8'h80;

  typedef enum logic [2:0] {
    RQ_NONE  = 3'd0,
    RQ_PROG  = 3'd1,
    RQ_SECT  = 3'd2,
    RQ_BLOCK = 3'd3,
    RQ_CHIP  = 3'd4,
    RQ_AAI   = 3'd5,
    RQ_WRSR  = 3'd6
  } req_kind_e;

  // Leading bytes of a frame that form the address.
  function automatic logic [2:0] addr_len(input logic [7:0] op, input logic in_aai, input logic [2:0] abytes);
    if (op == OP_PROG || op == OP_SECT || op == OP_BLOCK) return abytes;
    if (op == OP_AAI && !in_aai) return abytes;
    return 3'd0;
  endfunction
endpackage

// File: rtl/fwg_capture.sv
module fwg_capture #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_end,
  input  logic              in_aai,
  output logic              have_op,
  output logic [7:0]        cur_op,
  output logic [CNT_W-1:0]  nbytes,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  import flash_wguard_pkg::*;
  localparam int ABYTES = ADDR_W / 8;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] alen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_op <= 1'b0;
      cur_op  <= '0;
      nbytes  <= '0;
      addr    <= '0;
      data    <= '0;
      alen    <= '0;
    end else if (op_valid) begin
      have_op <= 1'b1;
      cur_op  <= op_code;
      nbytes  <= '0;
      addr    <= '0;
      data    <= '0;
      alen    <= CNT_W'(addr_len(op_code, in_aai, 3'(ABYTES)));
    end else if (cs_end) begin
      have_op <= 1'b0;
    end else if (byte_valid && have_op) begin
      if (nbytes < alen) addr <= {addr[ADDR_W-9:0], byte_data};
      else               data <= {data[DATA_W-9:0], byte_data};
      if (nbytes != CNT_MAX) nbytes <= nbytes + 1'b1;
    end
  end
endmodule

// File: rtl/fwg_policy.sv
module fwg_policy #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 3,
  parameter int SECT_BITS = 12,
  parameter int BLK_BITS  = 16
) (
  input  logic              frame_ok,
  input  logic [7:0]        cur_op,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wel,
  input  logic              swe,
  input  logic              busy,
  input  logic              in_aai,
  input  logic [ADDR_W-1:0] aai_addr,
  output logic              grant,
  output logic [2:0]        kind,
  output logic [ADDR_W-1:0] g_addr,
  output logic [DATA_W-1:0] g_data,
  output logic              set_wel,
  output logic              clr_wel,
  output logic              aai_start,
  output logic              aai_step,
  output logic              aai_stop,
  output logic              bo_on,
  output logic              bo_off
);
  import flash_wguard_pkg::*;
  localparam int ABYTES = ADDR_W / 8;

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a, input int bits);
    return a & ~((ADDR_W'(1) << bits) - ADDR_W'(1));
  endfunction

  logic ready;
  assign ready = wel && !busy && !in_aai;

  always_comb begin
    grant = 1'b0; kind = RQ_NONE; g_addr = '0; g_data = '0;
    set_wel = 1'b0; clr_wel = 1'b0;
    aai_start = 1'b0; aai_step = 1'b0; aai_stop = 1'b0;
    bo_on = 1'b0; bo_off = 1'b0;
    if (frame_ok) begin
      case (cur_op)
        OP_WREN:  set_wel = (nbytes == 0);
        OP_WRDI:  if (nbytes == 0) begin clr_wel = 1'b1; aai_stop = 1'b1; end
        OP_BOON:  bo_on  = (nbytes == 0);
        OP_BOOFF: bo_off = (nbytes == 0);
        OP_PROG: if (ready && nbytes == CNT_W'(ABYTES + 1)) begin
          grant = 1'b1; kind = RQ_PROG; g_addr = addr; g_data = data;
        end
        OP_SECT: if (ready && nbytes == CNT_W'(ABYTES)) begin
          grant = 1'b1; kind = RQ_SECT; g_addr = align_down(addr, SECT_BITS);
        end
        OP_BLOCK: if (ready && nbytes == CNT_W'(ABYTES)) begin
          grant = 1'b1; kind = RQ_BLOCK; g_addr = align_down(addr, BLK_BITS);
        end
        OP_CHIPA, OP_CHIPB: if (ready && nbytes == 0) begin
          grant = 1'b1; kind = RQ_CHIP;
        end
        OP_WRSR: if (swe && !busy && !in_aai && nbytes == 1) begin
          grant = 1'b1; kind = RQ_WRSR; g_data = data;
        end
        OP_AAI: begin
          if (in_aai) begin
            if (nbytes == 2) begin
              grant = 1'b1; kind = RQ_AAI; g_addr = aai_addr; g_data = data; aai_step = 1'b1;
            end
          end else if (ready && nbytes == CNT_W'(ABYTES + 2)) begin
            grant = 1'b1; kind = RQ_AAI; g_addr = addr; g_data = data; aai_start = 1'b1;
          end
        end
        default: ;
      endcase
      if (grant && kind != RQ_AAI) clr_wel = 1'b1;
    end
  end
endmodule

// File: rtl/flash_wguard.sv
module flash_wguard #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int SECT_BITS = 12,
  parameter int BLK_BITS  = 16,
  parameter int AAI_STEP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_end,
  input  logic              cs_aligned,
  input  logic              busy_in,
  output logic              req_valid,
  output logic [2:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [7:0]        status,
  output logic              aai_active,
  output logic              so_busy_sel
);
  import flash_wguard_pkg::*;
  localparam int CNT_W = 3;

  function automatic logic [ADDR_W-1:0] next_aai(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(AAI_STEP);
  endfunction

  logic              have_op;
  logic [7:0]        cur_op;
  logic [CNT_W-1:0]  nbytes;
  logic [ADDR_W-1:0] cap_addr, aai_addr, g_addr;
  logic [DATA_W-1:0] cap_data, g_data;
  logic              wel, swe, bo_mode;
  logic              frame_end, frame_ok;
  logic              grant, set_wel, clr_wel, aai_start, aai_step, aai_stop, bo_on, bo_off;
  logic [2:0]        kind;

  assign frame_end = cs_end && have_op;
  assign frame_ok  = frame_end && cs_aligned;

  fwg_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .byte_valid(byte_valid), .byte_data(byte_data), .cs_end(cs_end),
    .in_aai(aai_active), .have_op(have_op), .cur_op(cur_op), .nbytes(nbytes),
    .addr(cap_addr), .data(cap_data)
  );

  fwg_policy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
               .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS)) u_pol (
    .frame_ok(frame_ok), .cur_op(cur_op), .nbytes(nbytes), .addr(cap_addr),
    .data(cap_data), .wel(wel), .swe(swe), .busy(busy_in), .in_aai(aai_active),
    .aai_addr(aai_addr), .grant(grant), .kind(kind), .g_addr(g_addr), .g_data(g_data),
    .set_wel(set_wel), .clr_wel(clr_wel), .aai_start(aai_start), .aai_step(aai_step),
    .aai_stop(aai_stop), .bo_on(bo_on), .bo_off(bo_off)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel <= 1'b0; swe <= 1'b0; bo_mode <= 1'b0;
      aai_active <= 1'b0; aai_addr <= '0;
      req_valid <= 1'b0; req_kind <= RQ_NONE; req_addr <= '0; req_data <= '0;
    end else begin
      req_valid <= grant;
      if (grant) begin
        req_kind <= kind; req_addr <= g_addr; req_data <= g_data;
      end
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (frame_end) swe <= frame_ok && (cur_op == OP_EWSR) && (nbytes == 0);
      if (aai_start) begin
        aai_active <= 1'b1; aai_addr <= next_aai(g_addr);
      end else if (aai_step) begin
        aai_addr <= next_aai(aai_addr);
      end else if (aai_stop) begin
        aai_active <= 1'b0;
      end
      if (bo_on)       bo_mode <= 1'b1;
      else if (bo_off) bo_mode <= 1'b0;
    end
  end

  assign status      = {6'b0, wel, busy_in};
  assign so_busy_sel = bo_mode && aai_active;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !req_valid && !wel && !aai_active); // R1
  AST_PERMIT_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind inside {RQ_PROG, RQ_SECT, RQ_BLOCK, RQ_CHIP} |-> $past(wel)); // R3
  AST_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == RQ_SECT |-> req_addr[SECT_BITS-1:0] == '0); // R4
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end && !cs_aligned |=> !req_valid); // R5
  AST_STATUS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == RQ_WRSR |-> $past(swe)); // R6
  AST_PERMIT_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind != RQ_AAI |-> !wel); // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind != RQ_AAI |-> !$past(busy_in)); // R10
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R11
endmodule

// File: tb/tb_flash_wguard.sv
module tb_flash_wguard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, byte_valid = 1'b0, cs_end = 1'b0, cs_aligned = 1'b0, busy_in = 1'b0;
  logic [7:0] op_code = '0, byte_data = '0;
  logic req_valid, aai_active, so_busy_sel;
  logic [2:0] req_kind;
  logic [23:0] req_addr;
  logic [15:0] req_data;
  logic [7:0] status;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  flash_wguard dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .byte_valid(byte_valid), .byte_data(byte_data), .cs_end(cs_end),
    .cs_aligned(cs_aligned), .busy_in(busy_in), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .status(status), .aai_active(aai_active), .so_busy_sel(so_busy_sel)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  nb;
    logic [39:0] bytes;
    logic        al;
    logic        busy;
    logic        e_req;
    logic [2:0]  e_kind;
    logic [23:0] e_addr;
    logic [15:0] e_data;
    logic        e_wel;
    logic        e_aai;
    logic        e_sob;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{8'h02, 3'd4, 40'h00123455_00, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0}, // R3 no permit
    '{8'h06, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},           // R2
    '{8'h04, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0},           // R2
    '{8'h06, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},
    '{8'h20, 3'd3, 40'h123ABC0000, 1'b1, 1'b0, 1'b1, 3'd2, 24'h123000, 16'h0, 1'b0, 1'b0, 1'b0}, // R4 R8
    '{8'h06, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},
    '{8'hD8, 3'd3, 40'hABCDEF0000, 1'b1, 1'b0, 1'b1, 3'd3, 24'hAB0000, 16'h0, 1'b0, 1'b0, 1'b0}, // R4
    '{8'h06, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},
    '{8'hC7, 3'd0, 40'h0, 1'b1, 1'b0, 1'b1, 3'd4, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0},           // R4
    '{8'h06, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},
    '{8'h02, 3'd3, 40'h0001000000, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},  // R5 short
    '{8'h02, 3'd4, 40'h000100A500, 1'b0, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},  // R5 misaligned
    '{8'h02, 3'd4, 40'h000100A500, 1'b1, 1'b1, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},  // R10 busy
    '{8'h02, 3'd4, 40'h000100A500, 1'b1, 1'b0, 1'b1, 3'd1, 24'h000100, 16'h00A5, 1'b0, 1'b0, 1'b0}, // R3 R8
    '{8'h50, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0},
    '{8'h01, 3'd1, 40'h3C00000000, 1'b1, 1'b0, 1'b1, 3'd6, 24'h0, 16'h003C, 1'b0, 1'b0, 1'b0}, // R6
    '{8'h50, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0},
    '{8'h06, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},
    '{8'h01, 3'd1, 40'h1100000000, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},  // R6 cancelled
    '{8'h60, 3'd0, 40'h0, 1'b1, 1'b0, 1'b1, 3'd4, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0},           // R3
    '{8'h70, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0},           // R9
    '{8'h06, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},
    '{8'hAD, 3'd5, 40'h0002001234, 1'b1, 1'b0, 1'b1, 3'd5, 24'h000200, 16'h1234, 1'b1, 1'b1, 1'b1}, // R7 R9
    '{8'hAD, 3'd2, 40'h5678000000, 1'b1, 1'b1, 1'b1, 3'd5, 24'h000202, 16'h5678, 1'b1, 1'b1, 1'b1}, // R7 R10
    '{8'h20, 3'd3, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b1, 1'b1},          // R7 refused
    '{8'h04, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0},           // R8
    '{8'h80, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0},           // R9
    '{8'h06, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b1, 1'b0, 1'b0},
    '{8'hAD, 3'd5, 40'h000010BEEF, 1'b1, 1'b0, 1'b1, 3'd5, 24'h000010, 16'hBEEF, 1'b1, 1'b1, 1'b0}, // R9 mode off
    '{8'h04, 3'd0, 40'h0, 1'b1, 1'b0, 1'b0, 3'd0, 24'h0, 16'h0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Returns at the negedge where the outcome of the frame end is visible.
  task automatic frame(input logic [7:0] op, input int nb, input logic [39:0] b, input logic al);
    @(negedge clk); op_valid = 1'b1; op_code = op;
    @(negedge clk); op_valid = 1'b0;
    for (int i = 0; i < nb; i++) begin
      byte_valid = 1'b1; byte_data = b[39-8*i -: 8];
      @(negedge clk); byte_valid = 1'b0;
    end
    cs_end = 1'b1; cs_aligned = al;
    @(negedge clk); cs_end = 1'b0; cs_aligned = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!req_valid && status == 8'h00 && !aai_active && !so_busy_sel, "R1 reset",
          {req_valid, status, aai_active, so_busy_sel}, 64'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      busy_in = TBL[v].busy;
      frame(TBL[v].op, int'(TBL[v].nb), TBL[v].bytes, TBL[v].al);
      if (TBL[v].e_req)
        check(req_valid && req_kind == TBL[v].e_kind && req_addr == TBL[v].e_addr && req_data == TBL[v].e_data,
              "R3/R4/R7 request", {req_valid, req_kind, req_addr, req_data},
              {1'b1, TBL[v].e_kind, TBL[v].e_addr, TBL[v].e_data});
      else
        check(!req_valid, "R5 no request", req_valid, 0);
      check(status[1] == TBL[v].e_wel && aai_active == TBL[v].e_aai && so_busy_sel == TBL[v].e_sob,
            "R2/R8/R9 state", {status[1], aai_active, so_busy_sel},
            {TBL[v].e_wel, TBL[v].e_aai, TBL[v].e_sob});
      if (TBL[v].e_req) begin
        @(negedge clk);
        check(!req_valid, "R11 single pulse", req_valid, 0);
      end
      busy_in = 1'b0;
    end

    // R10: busy reflected at status bit 0
    busy_in = 1'b1;
    @(negedge clk);
    check(status == 8'h01, "R10 status busy", status, 8'h01);
    frame(8'h06, 0, 40'h0, 1'b1);
    check(status == 8'h03, "R2 permit while busy", status, 8'h03);
    busy_in = 1'b0;

    // R1: reset in mid-run clears the permit
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(status == 8'h00 && !req_valid, "R1 mid-run reset", status, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule